// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block compares two 32-bit single-precision floating-point operands and returns one result bit for a chosen predicate, along with an invalid-operation indication. The invalid indication is meant to be ORed into a status register outside the block. The predicates come in three groups. The ordered relations are equal, less-than and less-or-equal. There is a test for the unordered case. The unordered-or relations are unordered-or-equal, unordered-or-less and unordered-or-less-or-equal.

The predicates differ in how they treat NaN operands. Less-than and less-or-equal are signaling comparisons: any NaN operand raises invalid. All the other predicates are quiet: they raise invalid only when an operand is a signaling NaN. A caller sets `in_valid` for one cycle together with the operands and the predicate code. On the next clock edge the block registers the result and invalid bits and raises `out_valid`. The registered outputs hold their values until the next strobe.

Top module: `fp_compare_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid`, `flag` and `invalid` are all 0.
- R2: `out_valid` equals `in_valid` delayed by one clock. `flag` and `invalid` update only on an edge where `in_valid` is 1, and they hold their values on every other edge.
- R3: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. A NaN is signaling when bit 22 is 0 and quiet when bit 22 is 1. An all-ones exponent with a zero fraction is an infinity and is ordered.
- R4: Predicate code 0 (equal) gives 1 when the operands are numerically equal, including +0 against -0. It gives 0 when either operand is a NaN. It raises invalid only for a signaling NaN operand.
- R5: Predicate codes 1 (A less than B) and 2 (A less than or equal to B) are signaling. If either operand is a NaN, `invalid` is 1 and `flag` is 0.
- R6: Ordering follows sign and magnitude. Any negative value is less than any positive value, except that zeros of either sign are equal. Between two negative operands, the larger magnitude is the smaller value.
- R7: Predicate code 3 (unordered) gives 1 when either operand is a NaN. It raises invalid only for a signaling NaN operand.
- R8: Predicate codes 4 (unordered or equal), 5 (unordered or A less than B) and 6 (not A greater than B) are quiet and raise invalid only for a signaling NaN operand. Code 6 is 1 whenever A is not greater than B, which includes the unordered case.
- R9: Predicate code 7 is reserved and gives `flag` = 0 and `invalid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that marks a valid operand pair |
| op_a | input | 32 | Operand A, single precision |
| op_b | input | 32 | Operand B, single precision |
| pred_sel | input | 3 | Predicate code (0 eq, 1 lt, 2 le, 3 un, 4 ueq, 5 ult, 6 ule, 7 reserved) |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| flag | output | 1 | Predicate result |
| invalid | output | 1 | Invalid-operation indication |

## Verification
Random operands are drawn from several classes: raw bit patterns, signed zeros, infinities, quiet NaNs, signaling NaNs, values close to 1.0, and pairs that are identical or differ only in the lowest bit. These classes separate three things: equality from ordering, the two orderings that negative operands take, and the treatment of quiet versus signaling NaNs. Directed cases cover +0 against -0, infinity against a NaN and the reserved predicate code. One directed case checks that both outputs hold when the strobe is low. Every result is compared with a reference model that maps each value to a monotonic unsigned key and applies the predicate to those keys.

// File: rtl/fp_compare_unit.sv
module fp_compare_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [EXP_W+FRAC_W:0]       op_a,
  input  logic [EXP_W+FRAC_W:0]       op_b,
  input  logic [2:0]                  pred_sel,
  output logic                        out_valid,
  output logic                        flag,
  output logic                        invalid
);
  localparam int W = 1 + EXP_W + FRAC_W;

  localparam logic [2:0] P_EQ  = 3'd0;
  localparam logic [2:0] P_LT  = 3'd1;
  localparam logic [2:0] P_LE  = 3'd2;
  localparam logic [2:0] P_UN  = 3'd3;
  localparam logic [2:0] P_UEQ = 3'd4;
  localparam logic [2:0] P_ULT = 3'd5;
  localparam logic [2:0] P_ULE = 3'd6;

  logic a_nan, b_nan, a_snan, b_snan;
  logic any_nan, any_snan, both_zero;
  logic mag_lt, mag_eq;
  logic rel_eq, rel_lt;
  logic nxt_flag, nxt_inv;

  assign a_nan  = (&op_a[W-2:FRAC_W]) && (|op_a[FRAC_W-1:0]);
  assign b_nan  = (&op_b[W-2:FRAC_W]) && (|op_b[FRAC_W-1:0]);
  assign a_snan = a_nan && !op_a[FRAC_W-1];
  assign b_snan = b_nan && !op_b[FRAC_W-1];

  assign any_nan   = a_nan || b_nan;
  assign any_snan  = a_snan || b_snan;
  assign both_zero = ~|{op_a[W-2:0], op_b[W-2:0]};

  assign mag_lt = op_a[W-2:0] <  op_b[W-2:0];
  assign mag_eq = op_a[W-2:0] == op_b[W-2:0];

  assign rel_eq = !any_nan && (both_zero || (op_a == op_b));

  always_comb begin
    rel_lt = 1'b0;
    if (!any_nan && !both_zero) begin
      unique case ({op_a[W-1], op_b[W-1]})
        2'b00:   rel_lt = mag_lt;
        2'b11:   rel_lt = !mag_lt && !mag_eq;
        2'b10:   rel_lt = 1'b1;
        default: rel_lt = 1'b0;
      endcase
    end
  end

  always_comb begin
    nxt_flag = 1'b0;
    nxt_inv  = any_snan;
    unique case (pred_sel)
      P_EQ:  nxt_flag = rel_eq;
      P_LT:  begin nxt_flag = rel_lt;           nxt_inv = any_nan; end
      P_LE:  begin nxt_flag = rel_lt || rel_eq; nxt_inv = any_nan; end
      P_UN:  nxt_flag = any_nan;
      P_UEQ: nxt_flag = rel_eq || any_nan;
      P_ULT: nxt_flag = rel_lt || any_nan;
      P_ULE: nxt_flag = rel_lt || rel_eq || any_nan;
      default: begin nxt_flag = 1'b0; nxt_inv = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      flag      <= 1'b0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        flag    <= nxt_flag;
        invalid <= nxt_inv;
      end
    end
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(flag) && $stable(invalid)));

  // R5
  signaling_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (pred_sel == P_LT || pred_sel == P_LE) && any_nan)
      |=> (invalid && !flag));

  // R4
  signed_zero_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_sel == P_EQ && both_zero) |=> (flag && !invalid));

  // R7
  unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_sel == P_UN) |=> (flag == $past(any_nan)));

  // R8
  quiet_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_sel >= P_UEQ && pred_sel <= P_ULE && any_nan && !any_snan)
      |=> (flag && !invalid));

  // R9
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_sel == 3'd7) |=> (!flag && !invalid));
endmodule

// File: tb/test_fp_compare_unit.sv
module test_fp_compare_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [2:0] pred_sel = '0;
  logic out_valid, flag, invalid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  fp_compare_unit i_fp_compare_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .pred_sel(pred_sel), .out_valid(out_valid), .flag(flag), .invalid(invalid)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic bit is_nan(logic [31:0] x);
    return (x[30:23] == 8'hff) && (x[22:0] != 0);
  endfunction

  function automatic bit is_snan(logic [31:0] x);
    return is_nan(x) && !x[22];
  endfunction

  function automatic logic [31:0] okey(logic [31:0] x);
    if (x[30:0] == 0) return 32'h8000_0000;
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction

  function automatic logic [1:0] ref_cmp(logic [31:0] a, logic [31:0] b, logic [2:0] s);
    bit un, sn, lt, eq, gt, f, v;
    un = is_nan(a) || is_nan(b);
    sn = is_snan(a) || is_snan(b);
    lt = !un && (okey(a) < okey(b));
    eq = !un && (okey(a) == okey(b));
    gt = !un && !lt && !eq;
    case (s)
      3'd0: begin f = eq;       v = sn; end
      3'd1: begin f = lt;       v = un; end
      3'd2: begin f = lt || eq; v = un; end
      3'd3: begin f = un;       v = sn; end
      3'd4: begin f = eq || un; v = sn; end
      3'd5: begin f = lt || un; v = sn; end
      3'd6: begin f = !gt;      v = sn; end
      default: begin f = 1'b0;  v = 1'b0; end
    endcase
    return {f, v};
  endfunction

  function automatic string tag_of(logic [2:0] s);
    case (s)
      3'd0: return "R4";
      3'd1, 3'd2: return "R5";
      3'd3: return "R7";
      3'd7: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {out_valid,flag,invalid} actual=%b expected=%b a=%h b=%h sel=%0d",
               req, got, exp, op_a, op_b, pred_sel);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [31:0] b, logic [2:0] s, string req);
    logic [1:0] e;
    @(negedge clk);
    op_a = a; op_b = b; pred_sel = s; in_valid = 1'b1;
    e = ref_cmp(a, b, s);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, flag, invalid}, {1'b1, e});
  endtask

  function automatic logic [31:0] rand_op();
    logic [31:0] sp [8] = '{32'h0, 32'h8000_0000, 32'h7f80_0000, 32'hff80_0000,
                            32'h7fc0_0000, 32'h7f80_0001, 32'h3f80_0000, 32'hbf80_0000};
    logic sg;
    sg = 1'($urandom);
    case ($urandom % 6)
      0, 1: return $urandom;
      2: return sp[$urandom % 8];
      3: return {sg, 8'(8'd126 + $urandom % 3), 23'($urandom % 8)};
      4: return {sg, 8'hff, 1'($urandom), 22'($urandom % 4 + 1)};
      default: return {sg, 8'($urandom % 3), 23'($urandom)};
    endcase
  endfunction

  initial begin
    logic [31:0] a, b;
    logic [2:0] s;
    logic [2:0] held;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    // R1
    check("R1", {out_valid, flag, invalid}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, flag, invalid}, 3'b000);

    apply(32'h0000_0000, 32'h8000_0000, 3'd0, "R4");
    apply(32'h8000_0000, 32'h0000_0000, 3'd1, "R6");
    apply(32'hc000_0000, 32'hbf80_0000, 3'd1, "R6");
    apply(32'hbf80_0000, 32'hc000_0000, 3'd1, "R6");
    apply(32'hbf80_0000, 32'h3f80_0000, 3'd1, "R6");
    apply(32'h7fc0_0000, 32'h3f80_0000, 3'd1, "R5");
    apply(32'h3f80_0000, 32'h7fc0_0000, 3'd2, "R5");
    apply(32'h7fc0_0000, 32'h7fc0_0000, 3'd0, "R4");
    apply(32'h7fa0_0000, 32'h3f80_0000, 3'd0, "R3");
    apply(32'h7f80_0000, 32'h7f80_0000, 3'd3, "R3");
    apply(32'h7f80_0000, 32'hff80_0001, 3'd3, "R7");
    apply(32'h7fc0_0001, 32'h0, 3'd6, "R8");
    apply(32'h4000_0000, 32'h3f80_0000, 3'd6, "R8");
    apply(32'h3f80_0000, 32'h3f80_0000, 3'd7, "R9");
    apply(32'h7f80_0001, 32'h7f80_0001, 3'd7, "R9");

    // R2: outputs hold while strobe is low
    apply(32'h3f80_0000, 32'h3f80_0000, 3'd0, "R2");
    held = {out_valid, flag, invalid};
    @(negedge clk);
    op_a = 32'h7f80_0001; op_b = 32'h4000_0000; pred_sel = 3'd1; in_valid = 1'b0;
    @(negedge clk);
    check("R2", {out_valid, flag, invalid}, {1'b0, held[1:0]});

    for (int i = 0; i < 3000; i++) begin
      a = rand_op();
      case ($urandom % 5)
        0: b = a;
        1: b = a ^ 32'h1;
        default: b = rand_op();
      endcase
      s = 3'($urandom);
      apply(a, b, s, tag_of(s));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule